// File: doc/BRIEF.md
# Row-Masked Fuse Read Port

This block serves single-row reads from a behavioural one-time-programmable fuse store. A requester presents a read address on a valid/ready request channel. The block decodes an array select and a row number from fixed bit fields, turns the logical array number into a storage index, and fetches one 32-bit row from the store. It then ANDs that row with a column mask chosen by row, so that bits software must never see are hidden. The masked word is returned on a valid/ready response channel.

Each request also updates two completion flags that live in a shared interrupt status register: a read-done flag and a read-error flag. Array 1 is reserved, and a read aimed at it is refused. A refused read returns zero and raises the error flag. A request-enable pair gates the two flags onto an interrupt line. A write-one-to-clear pair lets software clear the flags.

The response path holds a single entry. A request is accepted when no response is pending or when the pending response is being taken in the same cycle. With a stalled consumer, the response word stays frozen and further requests wait. Accepted requests complete one cycle later, and the flags and the interrupt move in that same cycle.

Top module: `fuse_row_reader`

## Requirements
- R1: `req_ready` is high exactly when `rsp_valid` is low or `rsp_ready` is high. A request taken at a clock edge (`req_valid && req_ready`) makes `rsp_valid` high after that same edge.
- R2: The array select is `req_addr[12:11]` and the row is `req_addr[10:5]`. All other address bits have no effect on the result.
- R3: For array 0, the column mask by row is as follows. Row 0 shows only bits 31..28. Rows 8–15, 20, 22, 23 and 40–63 show all 32 bits. Row 16 shows bits 16..10 and 7..0. Row 17 shows bits 2..0. Row 21 shows bits 31..29 and 23..0.
- R4: An array 0 row not listed in R3, including rows 24–31, returns zero. It still completes as a permitted read: done is set and error is cleared.
- R5: Arrays 2 and 3 read storage index 1 and 2 (`fuse_ary`) at the same row, with no column masking. Array 0 reads storage index 0.
- R6: A read of array 1 returns data zero, sets `rd_err` and clears `rd_done`.
- R7: A permitted read sets `rd_done` and clears `rd_err`, in the cycle its response appears. `rd_done` and `rd_err` are never both high.
- R8: `irq` is high exactly when `rd_done && irq_en[0]` or `rd_err && irq_en[1]`. It changes in the same cycle as the flags.
- R9: `sts_clr[0]` clears `rd_done` and `sts_clr[1]` clears `rd_err` at the next edge. If a read completes at that edge, the completion's flag values win.
- R10: After reset, `rsp_valid`, `rsp_data`, `rd_done`, `rd_err` and `irq` are all zero.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` holds its value and no new request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 32 | Read address; array in [12:11], row in [10:5] |
| fuse_ary | output | 2 | Storage array index presented to the fuse store |
| fuse_row | output | 6 | Row presented to the fuse store |
| fuse_data | input | 32 | Row contents returned by the store in the same cycle |
| rsp_valid | output | 1 | Response word available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Masked row, or zero on a refused read |
| sts_clr | input | 2 | Write-one-to-clear: bit 0 done, bit 1 error |
| irq_en | input | 2 | Interrupt enables: bit 0 done, bit 1 error |
| rd_done | output | 1 | Read-done flag (bit 2 of the shared status register) |
| rd_err | output | 1 | Read-error flag (bit 3 of the shared status register) |
| irq | output | 1 | Interrupt request |

## Verification
Two situations are hard to reach from the ports. The first is the collision between a held response and a waiting request. Here the response must stay frozen while `req_ready` is low, and then the old word must leave at the same edge where the next request enters. The bench holds `rsp_ready` low after one read, parks a second request on the port for several cycles, and then releases `rsp_ready` for a single edge. A scoreboard checks that both words come out in order.

The second is the race between a flag clear and a completion at the same edge. To reach it, the bench first sets `rd_done` with a permitted read. It then drives `sts_clr[0]` during the cycle in which the next permitted read is accepted, and confirms that the flag survives.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

  localparam int unsigned FRD_DATA_W  = 32;
  localparam int unsigned FRD_ROW_W   = 6;
  localparam int unsigned FRD_ARY_W   = 2;
  localparam int unsigned FRD_ARY_LSB = 11;
  localparam int unsigned FRD_ROW_LSB = 5;

  // Flag slot positions inside the two-bit clear/enable vectors.
  localparam int unsigned FLG_DONE = 0;
  localparam int unsigned FLG_ERR  = 1;

  // Column visibility for array 0, computed per row at elaboration.
  function automatic logic [FRD_DATA_W-1:0] frd_row_mask(input int unsigned r);
    logic [FRD_DATA_W-1:0] m;
    m = '0;
    if (r == 0)                     m = 32'hF000_0000;
    else if (r >= 8 && r <= 15)     m = '1;
    else if (r == 16)               m = 32'h0001_FCFF;
    else if (r == 17)               m = 32'h0000_0007;
    else if (r == 20)               m = '1;
    else if (r == 21)               m = 32'hE0FF_FFFF;
    else if (r == 22 || r == 23)    m = '1;
    else if (r >= 40 && r <= 63)    m = '1;
    return m;
  endfunction

endpackage

// File: rtl/frd_addr_decode.sv
module frd_addr_decode #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned ARY_W      = 2,
  parameter int unsigned ROW_W      = 6,
  parameter int unsigned ARY_LSB    = 11,
  parameter int unsigned ROW_LSB    = 5,
  parameter int unsigned TABLE_ROWS = 64
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [ROW_W-1:0]  row,
  output logic [ARY_W-1:0]  phys_ary,
  output logic              permit,
  output logic              use_mask
);

  logic [ARY_W-1:0] ary;
  logic             addr_unused;

  assign ary         = addr[ARY_LSB +: ARY_W];
  assign row         = addr[ROW_LSB +: ROW_W];
  assign addr_unused = ^addr;

  always_comb begin
    permit   = 1'b0;
    use_mask = 1'b0;
    phys_ary = '0;
    if (ary == '0) begin
      permit   = (32'(row) < TABLE_ROWS);
      use_mask = 1'b1;
    end else if (ary == ARY_W'(1)) begin
      permit   = 1'b0;
    end else begin
      // reserved array 1 is skipped in storage
      permit   = 1'b1;
      phys_ary = ary - ARY_W'(1);
    end
  end

endmodule

// File: rtl/frd_col_mask.sv
module frd_col_mask
  import fuse_rd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ROW_W  = 6
) (
  input  logic [ROW_W-1:0]  row,
  output logic [DATA_W-1:0] mask
);

  localparam int unsigned NROWS = 1 << ROW_W;

  logic [DATA_W-1:0] tbl [NROWS];

  for (genvar g = 0; g < NROWS; g++) begin : g_row
    assign tbl[g] = DATA_W'(frd_row_mask(g));
  end

  assign mask = tbl[row];

endmodule

// File: rtl/frd_status.sv
module frd_status
  import fuse_rd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp,
  input  logic       cmp_ok,
  input  logic [1:0] clr,
  input  logic [1:0] en,
  output logic       done_q,
  output logic       err_q,
  output logic       irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (cmp) begin
      done_q <= cmp_ok;
      err_q  <= !cmp_ok;
    end else begin
      done_q <= done_q & ~clr[FLG_DONE];
      err_q  <= err_q & ~clr[FLG_ERR];
    end
  end

  assign irq = (done_q & en[FLG_DONE]) | (err_q & en[FLG_ERR]);

endmodule

// File: rtl/fuse_row_reader.sv
module fuse_row_reader
  import fuse_rd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = FRD_DATA_W,
  parameter int unsigned ARY_W      = FRD_ARY_W,
  parameter int unsigned ROW_W      = FRD_ROW_W,
  parameter int unsigned ARY_LSB    = FRD_ARY_LSB,
  parameter int unsigned ROW_LSB    = FRD_ROW_LSB,
  parameter int unsigned TABLE_ROWS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [ARY_W-1:0]  fuse_ary,
  output logic [ROW_W-1:0]  fuse_row,
  input  logic [DATA_W-1:0] fuse_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic [1:0]        sts_clr,
  input  logic [1:0]        irq_en,
  output logic              rd_done,
  output logic              rd_err,
  output logic              irq
);

  logic              permit;
  logic              use_mask;
  logic [DATA_W-1:0] col_mask;
  logic [DATA_W-1:0] gated;
  logic              take;

  frd_addr_decode #(
    .ADDR_W(ADDR_W), .ARY_W(ARY_W), .ROW_W(ROW_W),
    .ARY_LSB(ARY_LSB), .ROW_LSB(ROW_LSB), .TABLE_ROWS(TABLE_ROWS)
  ) u_dec (
    .addr    (req_addr),
    .row     (fuse_row),
    .phys_ary(fuse_ary),
    .permit  (permit),
    .use_mask(use_mask)
  );

  frd_col_mask #(.DATA_W(DATA_W), .ROW_W(ROW_W)) u_mask (
    .row (fuse_row),
    .mask(col_mask)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_comb begin
    if (!permit)       gated = '0;
    else if (use_mask) gated = fuse_data & col_mask;
    else               gated = fuse_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_data  <= gated;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  frd_status u_sts (
    .clk   (clk),
    .rst_n (rst_n),
    .cmp   (take),
    .cmp_ok(permit),
    .clr   (sts_clr),
    .en    (irq_en),
    .done_q(rd_done),
    .err_q (rd_err),
    .irq   (irq)
  );

endmodule

// File: rtl/fuse_row_reader_chk.sv
module fuse_row_reader_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ARY_W   = 2,
  parameter int unsigned ROW_W   = 6,
  parameter int unsigned ARY_LSB = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [ARY_W-1:0]  fuse_ary,
  input logic [ROW_W-1:0]  fuse_row,
  input logic [DATA_W-1:0] fuse_data,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [1:0]        sts_clr,
  input logic [1:0]        irq_en,
  input logic              rd_done,
  input logic              rd_err,
  input logic              irq
);

  logic [ARY_W-1:0] ary_f;
  logic             chk_unused;
  assign ary_f      = req_addr[ARY_LSB +: ARY_W];
  assign chk_unused = ^{fuse_row, fuse_data, sts_clr};

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  p_remap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ary_f == ARY_W'(2)) |-> (fuse_ary == ARY_W'(1)));

  p_deny_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && ary_f == ARY_W'(1)) |=>
      (rsp_data == '0 && rd_err && !rd_done));

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_done && rd_err));

  p_irq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 2'b00) |-> !irq);

  p_irq_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_err && irq_en[1]) |-> irq);

endmodule

bind fuse_row_reader fuse_row_reader_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARY_W(ARY_W),
  .ROW_W(ROW_W), .ARY_LSB(ARY_LSB)
) i_chk (.*);

// File: tb/test_fuse_row_reader.sv
`timescale 1ns/1ps
module test_fuse_row_reader;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  fuse_ary;
  logic [5:0]  fuse_row;
  logic [31:0] fuse_data;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic [1:0]  sts_clr = 2'b00;
  logic [1:0]  irq_en = 2'b00;
  logic        rd_done, rd_err, irq;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  logic [31:0] exp_d_q[$];
  logic        exp_e_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  fuse_row_reader i_fuse_row_reader (.*);

  // Behavioural fuse store contents.
  function automatic logic [31:0] store_row(input logic [1:0] a, input logic [5:0] r);
    return (32'h9E37_79B9 * {24'd0, a, r} + 32'h1) ^ {r, a, 24'hC3A55A};
  endfunction

  assign fuse_data = store_row(fuse_ary, fuse_row);

  function automatic logic [31:0] bench_mask(input int r);
    if (r == 0) return 32'hF000_0000;
    if (r >= 8 && r <= 15) return 32'hFFFF_FFFF;
    if (r == 16) return 32'h0001_FCFF;
    if (r == 17) return 32'h0000_0007;
    if (r == 21) return 32'hE0FF_FFFF;
    if (r == 20 || r == 22 || r == 23) return 32'hFFFF_FFFF;
    if (r >= 40 && r <= 63) return 32'hFFFF_FFFF;
    return 32'h0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_addr(input logic [1:0] a, input logic [5:0] r);
    return {19'd0, a, r, 5'd0};
  endfunction

  task automatic expect_of(input logic [31:0] addr, output logic [31:0] d,
                           output logic e);
    logic [1:0] a;
    logic [5:0] r;
    a = addr[12:11];
    r = addr[10:5];
    e = 1'b0;
    if (a == 2'd1) begin d = '0; e = 1'b1; end
    else if (a == 2'd0) d = store_row(2'd0, r) & bench_mask(int'(r));
    else d = store_row(a - 2'd1, r);
  endtask

  task automatic send(input logic [31:0] addr, input string tag);
    logic [31:0] d;
    logic e;
    expect_of(addr, d, e);
    req_addr  = addr;
    req_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    exp_d_q.push_back(d);
    exp_e_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_d_q.size() != 0) @(negedge clk);
    repeat (2) @(posedge clk);
    #1;
  endtask

  // Monitor: pop and compare as responses are taken.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid && rsp_ready) begin
        if (exp_d_q.size() == 0) begin
          check(1'b0, "R1 unexpected response", rsp_data, 32'h0);
        end else begin
          logic [31:0] d;
          logic e;
          string t;
          d = exp_d_q.pop_front();
          e = exp_e_q.pop_front();
          t = tag_q.pop_front();
          check(rsp_data == d, t, rsp_data, d);
          check(rd_err == e && rd_done == !e, {t, " flags R7"},
                {30'd0, rd_err, rd_done}, {30'd0, e, !e});
        end
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    check(!rsp_valid && !rd_done && !rd_err && !irq && rsp_data == 0,
          "R10 reset outputs", {28'd0, rsp_valid, rd_done, rd_err, irq}, 32'h0);
    check(req_ready, "R1 ready in reset", {31'd0, req_ready}, 32'h1);
    rst_n = 1'b1;
    @(posedge clk);
    #1;

    // R3 listed array 0 rows
    send(mk_addr(2'd0, 6'd0),  "R3 a0 row0");
    send(mk_addr(2'd0, 6'd8),  "R3 a0 row8");
    send(mk_addr(2'd0, 6'd15), "R3 a0 row15");
    send(mk_addr(2'd0, 6'd16), "R3 a0 row16");
    send(mk_addr(2'd0, 6'd17), "R3 a0 row17");
    send(mk_addr(2'd0, 6'd20), "R3 a0 row20");
    send(mk_addr(2'd0, 6'd21), "R3 a0 row21");
    send(mk_addr(2'd0, 6'd22), "R3 a0 row22");
    send(mk_addr(2'd0, 6'd23), "R3 a0 row23");
    send(mk_addr(2'd0, 6'd40), "R3 a0 row40");
    send(mk_addr(2'd0, 6'd63), "R3 a0 row63");
    // R4 unlisted rows
    send(mk_addr(2'd0, 6'd5),  "R4 a0 row5");
    send(mk_addr(2'd0, 6'd18), "R4 a0 row18");
    send(mk_addr(2'd0, 6'd24), "R4 a0 row24");
    send(mk_addr(2'd0, 6'd31), "R4 a0 row31");
    send(mk_addr(2'd0, 6'd39), "R4 a0 row39");
    // R5 remapped arrays
    send(mk_addr(2'd2, 6'd0),  "R5 a2 row0");
    send(mk_addr(2'd2, 6'd22), "R5 a2 row22");
    send(mk_addr(2'd3, 6'd7),  "R5 a3 row7");
    send(mk_addr(2'd3, 6'd63), "R5 a3 row63");
    // R6 reserved array
    send(mk_addr(2'd1, 6'd0),  "R6 a1 row0");
    send(mk_addr(2'd1, 6'd22), "R6 a1 row22");
    // R2 stray bits outside the fields
    send(32'hABCD_0000 | mk_addr(2'd0, 6'd16) | 32'h1F, "R2 junk a0 row16");
    send(32'h5000_6000 | mk_addr(2'd2, 6'd9) | 32'h0A, "R2 junk a2 row9");
    drain();

    // R8 interrupt gating
    irq_en = 2'b10;
    send(mk_addr(2'd1, 6'd3), "R6 a1 row3");
    check(irq == 1'b1, "R8 irq on error enabled", {31'd0, irq}, 32'h1);
    irq_en = 2'b01;
    #1;
    check(irq == 1'b0, "R8 irq error masked", {31'd0, irq}, 32'h0);
    drain();

    // R9 clear of error flag
    sts_clr = 2'b10;
    @(posedge clk);
    #1 sts_clr = 2'b00;
    check(!rd_err && !rd_done, "R9 error cleared",
          {30'd0, rd_err, rd_done}, 32'h0);
    irq_en = 2'b11;
    #1;
    check(irq == 1'b0, "R8 irq low after clear", {31'd0, irq}, 32'h0);

    // R9 completion wins over a simultaneous clear
    send(mk_addr(2'd0, 6'd9), "R9 setup a0 row9");
    check(rd_done && irq, "R8 irq on done", {30'd0, rd_done, irq}, 32'h3);
    sts_clr = 2'b01;
    send(mk_addr(2'd0, 6'd10), "R9 race a0 row10");
    sts_clr = 2'b00;
    check(rd_done == 1'b1, "R9 completion beats clear", {31'd0, rd_done}, 32'h1);
    drain();
    irq_en = 2'b00;

    // R11 / R1 back-pressure
    rsp_ready = 1'b0;
    send(mk_addr(2'd3, 6'd12), "R11 held a3 row12");
    held = store_row(2'd2, 6'd12);
    req_addr  = mk_addr(2'd0, 6'd16);
    req_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(rsp_valid && rsp_data == held, "R11 response held", rsp_data, held);
      check(!req_ready, "R1 no accept while stalled", {31'd0, req_ready}, 32'h0);
    end
    @(posedge clk);
    #1;
    begin
      logic [31:0] d;
      logic e;
      expect_of(req_addr, d, e);
      exp_d_q.push_back(d);
      exp_e_q.push_back(e);
      tag_q.push_back("R1 follow-on a0 row16");
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check(req_ready, "R1 ready when consumer takes", {31'd0, req_ready}, 32'h1);
    @(posedge clk);
    #1 req_valid = 1'b0;
    drain();
    check(exp_d_q.size() == 0 && !rsp_valid, "R1 queue drained",
          {31'd0, rsp_valid}, 32'h0);

    finish_run();
  end

endmodule